// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block walks a chain of transfer descriptors kept in memory. Each descriptor is a 48-byte record. The block reads it as a read burst of twelve 32-bit beats over a read-only memory-mapped master port and decodes it into the parameters of one transfer segment. It then offers that segment to a downstream transfer engine with a valid/ready handshake. When the engine reports the segment done, the fetcher does one of two things:

- It goes back to idle, if the record's final-descriptor flag is set.
- Otherwise, it fetches the record that the embedded next pointer names.

A per-record flag asks for a one-cycle completion interrupt once that record's segment has been moved.

Software starts a walk with three inputs: the first record's address, the descriptor-mode control bit, and a submit strobe. While descriptor mode is on, the cyclic-repeat permission for plain transfers is held off. A read response error poisons the record being fetched. The fetcher still accepts the rest of that burst, drops the record, returns to idle and raises a sticky error flag.

Top module: `sg_desc_fetcher`

## Requirements
- R1: Out of reset the block is idle. `busy`, `ar_valid`, `r_ready`, `xfer_valid`, `irq` and `err` are all low.
- R2: A walk starts only on a cycle where `submit` is high, `sg_mode` is high and the block is idle. A submit while busy, or with `sg_mode` low, changes nothing. `busy` is high from the cycle after the accepted submit until the walk ends.
- R3: Each record is requested with one read request. `ar_addr` is the record address with bits [2:0] forced to zero, and `ar_len` is 11 (beats minus one). `ar_valid` stays high until `ar_ready` is seen.
- R4: Beat k of the burst holds record bytes 4k..4k+3, little-endian. The beat map is:
  - beat 0: flags
  - beat 1: id
  - beats 2/3: destination address, low word then high word
  - beats 4/5: source address, low then high
  - beats 6/7: next pointer, low then high
  - beat 8: y length
  - beat 9: x length (byte count minus one)
  - beat 10: source stride
  - beat 11: destination stride
  
  The id, both addresses, both lengths and both strides appear unchanged on the `xfer_*` outputs.
- R5: `xfer_valid` rises after the twelfth beat of an error-free burst. It and all `xfer_*` fields hold steady until `xfer_ready` is seen.
- R6: On `seg_done`, if flag bit 0 of the current record is set, the walk ends and the block goes idle. Otherwise the next read request goes to the next pointer with bits [2:0] forced to zero.
- R7: After a segment is accepted, no read request is made before `seg_done` arrives.
- R8: `irq` pulses for exactly the one cycle after `seg_done` when flag bit 1 of the current record is set, and stays low otherwise.
- R9: If any beat of a burst has `r_err` high, all twelve beats are still accepted. No segment is offered, the block goes idle, and `err` rises and holds until the next accepted submit clears it.
- R10: `cyclic_en` equals `cyclic_req` while `sg_mode` is low and is forced low while `sg_mode` is high.
- R11: `r_ready` is high only while the twelve beats of a requested record are being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| first_addr | input | 64 | Address of the first record of the chain |
| sg_mode | input | 1 | Descriptor-mode control bit |
| submit | input | 1 | Start strobe |
| cyclic_req | input | 1 | Requested cyclic repeat for plain transfers |
| cyclic_en | output | 1 | Cyclic repeat permission after masking |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| ar_addr | output | 64 | Read request address |
| ar_len | output | 8 | Burst length minus one |
| r_valid | input | 1 | Read beat valid |
| r_ready | output | 1 | Read beat accepted |
| r_data | input | 32 | Read beat data |
| r_err | input | 1 | Read beat error response |
| xfer_valid | output | 1 | Segment offered to transfer engine |
| xfer_ready | input | 1 | Transfer engine takes the segment |
| xfer_id | output | 32 | Record identifier |
| xfer_dst_addr | output | 64 | Destination address |
| xfer_src_addr | output | 64 | Source address |
| xfer_x_len | output | 32 | Bytes per row minus one |
| xfer_y_len | output | 32 | Row count field |
| xfer_src_stride | output | 32 | Source row stride |
| xfer_dst_stride | output | 32 | Destination row stride |
| seg_done | input | 1 | Transfer engine finished the current segment |
| irq | output | 1 | Completion interrupt pulse |
| busy | output | 1 | A walk is in progress |
| err | output | 1 | Sticky read-error flag |

## Verification
The hardest situation to reach from the ports is an error response in the middle of a burst, with beats still to come, followed by a recovery. Recovery needs a fresh submit that must clear the sticky flag and walk a clean chain. The memory model in the bench is armed to flag the sixth beat of one chosen record while `r_valid` and `ar_ready` stall at random. A second walk then starts from a clean record. The chain also uses an unaligned first address and an unaligned next pointer, and a second submit is sent mid-walk, so alignment masking and the ignoring of a busy submit are both seen at `ar_addr`.

// File: rtl/sg_fetch_pkg.sv
// Shared types and record layout for the descriptor fetcher.
// Assumes 32-bit read beats and a 48-byte record.
package sg_fetch_pkg;

    localparam int BEAT_W     = 32;
    localparam int DESC_WORDS = 12;

    // Word index of each field inside the record (little-endian beats)
    localparam int WI_FLAGS   = 0;
    localparam int WI_ID      = 1;
    localparam int WI_DST     = 2;
    localparam int WI_SRC     = 4;
    localparam int WI_NEXT    = 6;
    localparam int WI_YLEN    = 8;
    localparam int WI_XLEN    = 9;
    localparam int WI_SSTRIDE = 10;
    localparam int WI_DSTRIDE = 11;

    // Flag bit positions
    localparam int FLAG_LAST = 0;
    localparam int FLAG_IRQ  = 1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_BEATS = 3'd2,
        ST_OFFER = 3'd3,
        ST_HOLD  = 3'd4
    } sg_state_e;

    typedef struct packed {
        logic [31:0] flags;
        logic [31:0] id;
        logic [63:0] dst;
        logic [63:0] src;
        logic [63:0] nxt;
        logic [31:0] ylen;
        logic [31:0] xlen;
        logic [31:0] sstride;
        logic [31:0] dstride;
    } sg_desc_t;

endpackage

// File: rtl/sg_beat_collector.sv
// Stores the beats of one record burst into per-word registers, counts
// them and accumulates any error response seen in the burst.
// Assumes beats arrive in address order and clear precedes each burst.
module sg_beat_collector #(
    parameter int WORDS = 12,
    parameter int BW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              beat_valid,
    input  logic [BW-1:0]     beat_data,
    input  logic              beat_err,
    output logic [WORDS*BW-1:0] record,
    output logic              last_beat,
    output logic              err_any
);
    localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [IW-1:0] idx;
    logic          err_acc;

    // Beat position counter, restarted at each burst
    always_ff @(posedge clk) begin
        if (!rst_n)          idx <= '0;
        else if (clear)      idx <= '0;
        else if (beat_valid) idx <= idx + 1'b1;
    end

    // Error accumulator for the burst in progress
    always_ff @(posedge clk) begin
        if (!rst_n)                     err_acc <= 1'b0;
        else if (clear)                 err_acc <= 1'b0;
        else if (beat_valid && beat_err) err_acc <= 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < WORDS; g++) begin : g_word
            logic [BW-1:0] word_q;
            // Capture the beat whose index matches this word
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (beat_valid && (idx == IW'(g)))
                    word_q <= beat_data;
            end
            assign record[g*BW +: BW] = word_q;
        end
    endgenerate

    assign last_beat = beat_valid && (idx == IW'(WORDS-1));
    assign err_any   = err_acc || (beat_valid && beat_err);

endmodule

// File: rtl/sg_desc_decode.sv
// Slices the flat record into named fields.
// Assumes the word map of sg_fetch_pkg; purely combinational.
module sg_desc_decode
    import sg_fetch_pkg::*;
(
    input  logic [DESC_WORDS*BEAT_W-1:0] record,
    output sg_desc_t                     desc
);
    // Pick one 32-bit word of the record
    function automatic logic [31:0] wd(input int i);
        return record[i*BEAT_W +: BEAT_W];
    endfunction

    // Field extraction
    always_comb begin
        desc.flags   = wd(WI_FLAGS);
        desc.id      = wd(WI_ID);
        desc.dst     = {wd(WI_DST+1),  wd(WI_DST)};
        desc.src     = {wd(WI_SRC+1),  wd(WI_SRC)};
        desc.nxt     = {wd(WI_NEXT+1), wd(WI_NEXT)};
        desc.ylen    = wd(WI_YLEN);
        desc.xlen    = wd(WI_XLEN);
        desc.sstride = wd(WI_SSTRIDE);
        desc.dstride = wd(WI_DSTRIDE);
    end

endmodule

// File: rtl/sg_chain_ctrl.sv
// Sequencer of the walk: idle, request, beat collection, offer, wait.
// Assumes the record fields are stable from the last beat until the next
// request, which holds because beats are only taken in ST_BEATS.
module sg_chain_ctrl
    import sg_fetch_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          submit,
    input  logic          sg_mode,
    input  logic [AW-1:0] first_addr,
    input  logic          ar_ready,
    input  logic          last_beat,
    input  logic          err_any,
    input  logic          xfer_ready,
    input  logic          seg_done,
    input  logic          flag_last,
    input  logic          flag_irq,
    input  logic [63:0]   next_ptr,
    output sg_state_e     state,
    output logic [AW-1:0] cur_addr,
    output logic          burst_clear,
    output logic          irq,
    output logic          err
);
    sg_state_e state_n;

    // Next-state selection
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (submit && sg_mode) state_n = ST_REQ;
            ST_REQ:   if (ar_ready)          state_n = ST_BEATS;
            ST_BEATS: if (last_beat)         state_n = err_any ? ST_IDLE : ST_OFFER;
            ST_OFFER: if (xfer_ready)        state_n = ST_HOLD;
            ST_HOLD:  if (seg_done)          state_n = flag_last ? ST_IDLE : ST_REQ;
            default:                         state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Record address: first address on start, next pointer on chaining
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (state == ST_IDLE && submit && sg_mode)
            cur_addr <= {first_addr[AW-1:3], 3'b000};
        else if (state == ST_HOLD && seg_done && !flag_last)
            cur_addr <= {next_ptr[AW-1:3], 3'b000};
    end

    // Completion interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state == ST_HOLD) && seg_done && flag_irq;
    end

    // Sticky error: set on a poisoned burst, cleared by an accepted submit
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (state == ST_IDLE && submit && sg_mode)
            err <= 1'b0;
        else if (state == ST_BEATS && last_beat && err_any)
            err <= 1'b1;
    end

    assign burst_clear = (state == ST_REQ) && ar_ready;

endmodule

// File: rtl/sg_desc_fetcher.sv
// Top of the descriptor fetcher: read request, beat collection, decode,
// offer to the transfer engine and chaining.
// Assumes one outstanding read burst and one outstanding segment.
module sg_desc_fetcher
    import sg_fetch_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] first_addr,
    input  logic          sg_mode,
    input  logic          submit,
    input  logic          cyclic_req,
    output logic          cyclic_en,
    output logic          ar_valid,
    input  logic          ar_ready,
    output logic [AW-1:0] ar_addr,
    output logic [7:0]    ar_len,
    input  logic          r_valid,
    output logic          r_ready,
    input  logic [31:0]   r_data,
    input  logic          r_err,
    output logic          xfer_valid,
    input  logic          xfer_ready,
    output logic [31:0]   xfer_id,
    output logic [63:0]   xfer_dst_addr,
    output logic [63:0]   xfer_src_addr,
    output logic [31:0]   xfer_x_len,
    output logic [31:0]   xfer_y_len,
    output logic [31:0]   xfer_src_stride,
    output logic [31:0]   xfer_dst_stride,
    input  logic          seg_done,
    output logic          irq,
    output logic          busy,
    output logic          err
);
    localparam int REC_W = DESC_WORDS * BEAT_W;

    sg_state_e          state;
    logic [AW-1:0]      cur_addr;
    logic               burst_clear;
    logic               beat_valid;
    logic               last_beat;
    logic               err_any;
    logic [REC_W-1:0]   record;
    sg_desc_t           desc;

    assign beat_valid = r_valid && r_ready;

    sg_beat_collector #(.WORDS(DESC_WORDS), .BW(BEAT_W)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (burst_clear),
        .beat_valid (beat_valid),
        .beat_data  (r_data),
        .beat_err   (r_err),
        .record     (record),
        .last_beat  (last_beat),
        .err_any    (err_any)
    );

    sg_desc_decode u_decode (
        .record (record),
        .desc   (desc)
    );

    sg_chain_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .submit      (submit),
        .sg_mode     (sg_mode),
        .first_addr  (first_addr),
        .ar_ready    (ar_ready),
        .last_beat   (last_beat),
        .err_any     (err_any),
        .xfer_ready  (xfer_ready),
        .seg_done    (seg_done),
        .flag_last   (desc.flags[FLAG_LAST]),
        .flag_irq    (desc.flags[FLAG_IRQ]),
        .next_ptr    (desc.nxt),
        .state       (state),
        .cur_addr    (cur_addr),
        .burst_clear (burst_clear),
        .irq         (irq),
        .err         (err)
    );

    // Port-side views of the sequencer state
    assign ar_valid        = (state == ST_REQ);
    assign ar_addr         = cur_addr;
    assign ar_len          = 8'(DESC_WORDS - 1);
    assign r_ready         = (state == ST_BEATS);
    assign xfer_valid      = (state == ST_OFFER);
    assign busy            = (state != ST_IDLE);
    assign cyclic_en       = cyclic_req && !sg_mode;

    assign xfer_id         = desc.id;
    assign xfer_dst_addr   = desc.dst;
    assign xfer_src_addr   = desc.src;
    assign xfer_x_len      = desc.xlen;
    assign xfer_y_len      = desc.ylen;
    assign xfer_src_stride = desc.sstride;
    assign xfer_dst_stride = desc.dstride;

endmodule

// File: rtl/sg_fetch_chk.sv
// Protocol checks for sg_desc_fetcher, attached by bind.
module sg_fetch_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sg_mode,
    input logic          submit,
    input logic          cyclic_en,
    input logic          ar_valid,
    input logic          ar_ready,
    input logic [AW-1:0] ar_addr,
    input logic          r_ready,
    input logic          xfer_valid,
    input logic          xfer_ready,
    input logic [31:0]   xfer_id,
    input logic [31:0]   xfer_x_len,
    input logic [63:0]   xfer_src_addr,
    input logic          irq,
    input logic          busy,
    input logic          err
);
    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(submit && sg_mode)) |=> !busy);

    // R3
    ar_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (ar_addr[2:0] == 3'b000));

    // R3
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));

    // R5
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_id)
            && $stable(xfer_x_len) && $stable(xfer_src_addr)));

    // R7
    no_fetch_while_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_ready) |=> !ar_valid);

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !submit) |=> err);

    // R10
    cyclic_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sg_mode |-> !cyclic_en);

    // R11
    rready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_ready |-> (!ar_valid && !xfer_valid && busy));

endmodule

bind sg_desc_fetcher sg_fetch_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sg_mode       (sg_mode),
    .submit        (submit),
    .cyclic_en     (cyclic_en),
    .ar_valid      (ar_valid),
    .ar_ready      (ar_ready),
    .ar_addr       (ar_addr),
    .r_ready       (r_ready),
    .xfer_valid    (xfer_valid),
    .xfer_ready    (xfer_ready),
    .xfer_id       (xfer_id),
    .xfer_x_len    (xfer_x_len),
    .xfer_src_addr (xfer_src_addr),
    .irq           (irq),
    .busy          (busy),
    .err           (err)
);

// File: tb/sg_desc_fetcher_tb.sv
module sg_desc_fetcher_tb;
    localparam int CLK_P    = 10;
    localparam int WD_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] first_addr = '0;
    logic        sg_mode = 1'b0;
    logic        submit = 1'b0;
    logic        cyclic_req = 1'b0;
    logic        cyclic_en;
    logic        ar_valid;
    logic        ar_ready = 1'b0;
    logic [63:0] ar_addr;
    logic [7:0]  ar_len;
    logic        r_valid = 1'b0;
    logic        r_ready;
    logic [31:0] r_data = '0;
    logic        r_err = 1'b0;
    logic        xfer_valid;
    logic        xfer_ready = 1'b0;
    logic [31:0] xfer_id, xfer_x_len, xfer_y_len, xfer_src_stride, xfer_dst_stride;
    logic [63:0] xfer_dst_addr, xfer_src_addr;
    logic        seg_done = 1'b0;
    logic        irq, busy, err;

    always #(CLK_P/2) clk = ~clk;

    sg_desc_fetcher u_dut (
        .clk(clk), .rst_n(rst_n), .first_addr(first_addr), .sg_mode(sg_mode),
        .submit(submit), .cyclic_req(cyclic_req), .cyclic_en(cyclic_en),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_err(r_err),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_id(xfer_id),
        .xfer_dst_addr(xfer_dst_addr), .xfer_src_addr(xfer_src_addr),
        .xfer_x_len(xfer_x_len), .xfer_y_len(xfer_y_len),
        .xfer_src_stride(xfer_src_stride), .xfer_dst_stride(xfer_dst_stride),
        .seg_done(seg_done), .irq(irq), .busy(busy), .err(err)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Bench memory, word addressed by byte address
    logic [31:0] mem [logic [63:0]];

    function automatic logic [31:0] mem_rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic put_desc(input logic [63:0] base, input logic [31:0] flags,
                            input logic [31:0] id, input logic [63:0] dst,
                            input logic [63:0] src, input logic [63:0] nxt,
                            input logic [31:0] yl, input logic [31:0] xl,
                            input logic [31:0] ss, input logic [31:0] ds);
        mem[base+0]  = flags;      mem[base+4]  = id;
        mem[base+8]  = dst[31:0];  mem[base+12] = dst[63:32];
        mem[base+16] = src[31:0];  mem[base+20] = src[63:32];
        mem[base+24] = nxt[31:0];  mem[base+28] = nxt[63:32];
        mem[base+32] = yl;         mem[base+36] = xl;
        mem[base+40] = ss;         mem[base+44] = ds;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Stimulus-side responders
    logic [15:0] lfsr = 16'hACE1;
    bit          rsp_pend = 0;
    logic [63:0] rsp_addr = '0;
    int          rsp_k = 0;
    int          eng_cnt = 0;
    bit          err_arm = 0;
    logic [63:0] err_addr = '0;

    // Reference model state (0 idle,1 request,2 beats,3 offer,4 wait)
    int          m_st = 0;
    logic [63:0] m_cur = '0;
    int          m_cnt = 0;
    bit          m_bad = 0;
    bit          m_err = 0;
    bit          m_irq = 0;

    // Model update and responder bookkeeping on the active edge
    always @(posedge clk) begin
        logic [31:0] f;
        bit irq_n;
        irq_n = 0;
        if (!rst_n) begin
            m_st = 0; m_cur = '0; m_cnt = 0; m_bad = 0; m_err = 0;
            rsp_pend = 0; rsp_k = 0; eng_cnt = 0;
        end else begin
            if (ar_valid && ar_ready) begin rsp_addr = ar_addr; rsp_k = 0; rsp_pend = 1; end
            else if (r_valid && r_ready) begin
                rsp_k++;
                if (rsp_k == 12) rsp_pend = 0;
            end
            if (xfer_valid && xfer_ready) eng_cnt = 3;
            else if (eng_cnt > 0) eng_cnt--;

            case (m_st)
                0: if (submit && sg_mode) begin
                       m_cur = {first_addr[63:3], 3'b000}; m_err = 0; m_st = 1;
                   end
                1: if (ar_ready) begin m_st = 2; m_cnt = 0; m_bad = 0; end
                2: if (r_valid) begin
                       if (r_err) m_bad = 1;
                       if (m_cnt == 11) begin
                           if (m_bad) begin m_err = 1; m_st = 0; end
                           else m_st = 3;
                       end
                       m_cnt++;
                   end
                3: if (xfer_ready) m_st = 4;
                4: if (seg_done) begin
                       f = mem_rd(m_cur);
                       irq_n = f[1];
                       if (f[0]) m_st = 0;
                       else begin
                           m_cur = {mem_rd(m_cur+28), mem_rd(m_cur+24) & 32'hFFFF_FFF8};
                           m_st = 1;
                       end
                   end
                default: m_st = 0;
            endcase
        end
        m_irq = irq_n;
    end

    // Responder drive on the falling edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ar_ready   <= lfsr[0];
        xfer_ready <= lfsr[3] | lfsr[5];
        seg_done   <= (eng_cnt == 1);
        if (rsp_pend && rsp_k < 12 && (lfsr[1] | lfsr[7])) begin
            r_valid <= 1'b1;
            r_data  <= mem_rd(rsp_addr + 64'(4*rsp_k));
            r_err   <= err_arm && (rsp_addr == err_addr) && (rsp_k == 5);
        end else begin
            r_valid <= 1'b0;
            r_data  <= 32'hDEAD_BEEF;
            r_err   <= 1'b0;
        end
    end

    // Cycle-by-cycle comparison, a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n) begin
            chk("R2 busy", busy, m_st != 0);
            chk("R3 R7 ar_valid", ar_valid, m_st == 1);
            if (m_st == 1) begin
                chk("R3 R6 ar_addr", ar_addr, m_cur);
                chk("R3 ar_len", ar_len, 64'd11);
            end
            chk("R11 r_ready", r_ready, m_st == 2);
            chk("R5 xfer_valid", xfer_valid, m_st == 3);
            if (m_st == 3) begin
                chk("R4 id", xfer_id, mem_rd(m_cur+4));
                chk("R4 dst", xfer_dst_addr, {mem_rd(m_cur+12), mem_rd(m_cur+8)});
                chk("R4 src", xfer_src_addr, {mem_rd(m_cur+20), mem_rd(m_cur+16)});
                chk("R4 ylen", xfer_y_len, mem_rd(m_cur+32));
                chk("R4 xlen", xfer_x_len, mem_rd(m_cur+36));
                chk("R4 sstride", xfer_src_stride, mem_rd(m_cur+40));
                chk("R4 dstride", xfer_dst_stride, mem_rd(m_cur+44));
            end
            chk("R8 irq", irq, m_irq);
            chk("R9 err", err, m_err);
            chk("R10 cyclic_en", cyclic_en, cyclic_req && !sg_mode);
        end
    end

    task automatic do_submit(input logic [63:0] a);
        @(negedge clk);
        first_addr <= a;
        submit <= 1'b1;
        @(negedge clk);
        submit <= 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_st != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still summarises
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Chain: unaligned next pointer, irq on middle and last, 2D fields
        put_desc(64'h1000, 32'h0, 32'hA0, 64'h1_2345_6780, 64'h9_8765_4320,
                 64'h2005, 32'h0, 32'h3F, 32'h0, 32'h0);
        put_desc(64'h2000, 32'h2, 32'hA1, 64'hFFFF_0000_1111_2222, 64'h0000_0001_0000_0000,
                 64'h3000, 32'h7, 32'hFF, 32'h100, 32'h200);
        put_desc(64'h3000, 32'h3, 32'hA2, 64'h55, 64'hAA,
                 64'h1000, 32'h0, 32'h0, 32'h0, 32'h0);
        put_desc(64'h4000, 32'h0, 32'hBAD, 64'h1, 64'h2, 64'h1000, 32'h0, 32'h7, 32'h0, 32'h0);
        put_desc(64'h5000, 32'h1, 32'hC0, 64'h3, 64'h4, 64'h0, 32'h0, 32'h1, 32'h0, 32'h0);

        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        #(CLK_P/4);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 ar_valid", ar_valid, 0);
        chk("R1 r_ready", r_ready, 0);
        chk("R1 xfer_valid", xfer_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 err", err, 0);

        // R10 with mode off; R2 submit without mode is ignored
        cyclic_req <= 1'b1;
        do_submit(64'h1000);
        repeat (4) @(negedge clk);
        #(CLK_P/4);
        chk("R2 no start without mode", busy, 0);

        // Main chain, with a busy-time submit that must be ignored
        sg_mode <= 1'b1;
        do_submit(64'h1003);
        repeat (5) @(negedge clk);
        first_addr <= 64'h5000;
        submit <= 1'b1;
        @(negedge clk);
        submit <= 1'b0;
        wait_idle();
        #(CLK_P/4);
        chk("R6 idle after last", busy, 0);

        // R9: error mid-burst, then recovery on a clean record
        err_arm = 1; err_addr = 64'h4000;
        do_submit(64'h4000);
        wait_idle();
        #(CLK_P/4);
        chk("R9 err after bad burst", err, 1);
        chk("R9 idle after bad burst", busy, 0);
        err_arm = 0;
        do_submit(64'h5000);
        wait_idle();
        #(CLK_P/4);
        chk("R9 err cleared by submit", err, 0);

        sg_mode <= 1'b0;
        repeat (4) @(negedge clk);
        #(CLK_P/4);
        chk("R10 cyclic restored", cyclic_en, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule